// File: doc/BRIEF.md
# Framed Serial Deserializer with Word-Clock Regeneration

This block sits behind the receive side of a source-synchronous serial link. It samples one serial data bit on every rising edge of the incoming bit clock and finds the frame boundaries from a two-bit marker that follows every 12-bit data word. Each word that carries a valid marker is placed on a 12-bit parallel output, and a word-clock pulse is produced for it. Frames made only of zeros are idle filler. They produce neither a word nor a pulse and do not disturb the alignment.

A pad mode accepts a transmitter that stretches one frame in every group of three by two extra bit times. The extra bits lead that frame's slot and are dropped whatever their value. The parallel output has a separate output-enable for a bidirectional pad. When the block is turned to the transmit direction, the enable drops and the last received word stays in the data register. When the block is powered down, the enable drops and all internal state clears.

Top module: `framed_deser`

## Requirements
- R1: A frame is 14 bits in arrival order: data bit 0 first through data bit 11, then a marker 1, then a marker 0. The word presented is data bit n on `dp_o[n]`.
- R2: While unaligned, any received 1 immediately followed by a 0 is a candidate marker. Alignment is declared when a second marker ends exactly one frame later: 14 bits later without pad mode, or 16 bits later with pad mode. The frame that completes alignment is the first word output. Frames before it are not output.
- R3: With `pad_mode` high, slots run in a repeating order of 16, 14, 14 bits. The slot that completes alignment is a 16-bit slot. The two leading bits of a 16-bit slot are ignored for any value.
- R4: While aligned, a slot whose 14 frame bits are all zero is idle. It leaves `dp_o` unchanged, produces no word-clock pulse and keeps the alignment.
- R5: While aligned, a slot ending with neither a valid marker nor all zeros drops the alignment. No word is output, and the search of R2 restarts.
- R6: `dp_o` takes a new word on the clock edge that samples the final marker bit of that word's frame.
- R7: `wclk` is high at rest. It goes low 8 bit clocks after the edge that updated `dp_o` and stays low for exactly 13 bit clocks, once per output word.
- R8: With `en` high and `dir_tx` high, `dp_oe` is 0, `dp_o` holds its last word, `wclk` is high and no frames are decoded. Returning to receive requires a fresh alignment.
- R9: With `en` low, `dp_oe` is 0. From the next clock edge `dp_o` is 0 and `wclk` is high, and all alignment is lost.
- R10: After reset, `dp_o` is 0 and `wclk` is high. `dp_oe` equals `en` AND NOT `dir_tx` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered serial bit clock; one data bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active operation; low is power-down |
| dir_tx | input | 1 | 1 turns the port to the transmit direction and stops the receiver |
| pad_mode | input | 1 | Accept the 16-14-14 stretched slot pattern |
| sdata | input | 1 | Serial data bit |
| dp_o | output | 12 | Last received data word |
| dp_oe | output | 1 | Output-enable for the parallel pad drivers |
| wclk | output | 1 | Regenerated word clock, low phase marks a word |

## Verification
Back-to-back valid frames are 14 bit times apart, but the word-clock low phase lasts 13 bit times and starts 8 bit times after its data. As a result, the next `dp_o` update lands in the middle of the previous word's low phase, and the rising edge of `wclk` comes just one cycle before the next falling edge. The bench provokes this with long runs of consecutive words, with and without interleaved idle and padded slots. A behavioural model tracks every scheduled pulse as an edge index in a queue and judges `dp_o`, `dp_oe` and `wclk` together on every cycle. Direction reversal and power-down are applied while pulses are pending, so that the clearing of scheduled pulses is judged as well.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    FS_HUNT    = 2'd0,
    FS_CONFIRM = 2'd1,
    FS_TRACK   = 2'd2
  } fs_t;

  // Marker is an older 1 followed by a newer 0.
  function automatic logic marker_at(logic older, logic newer);
    return older & ~newer;
  endfunction

  // Bits in the current slot: stretched only in pad mode on the padded slot.
  function automatic int unsigned slot_bits(logic pad_on, logic pad_slot,
                                            int unsigned frame_w, int unsigned pad_w);
    return (pad_on && pad_slot) ? frame_w + pad_w : frame_w;
  endfunction

endpackage

// File: rtl/dsr_shift.sv
module dsr_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sin,
  output logic [W-1:0] win_nx
);

  logic [W-1:0] win_q;

  // Newest bit enters at the top; oldest bit sits at index 0.
  assign win_nx = {sin, win_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_q <= '0;
    else if (clr) win_q <= '0;
    else          win_q <= win_nx;
  end

endmodule

// File: rtl/dsr_framer.sv
module dsr_framer
  import dsr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PAD_W  = 2,
  parameter int GROUP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pad_mode,
  input  logic [DATA_W+1:0] win_nx,
  output logic              word_evt,
  output logic [DATA_W-1:0] word
);

  localparam int FW = DATA_W + 2;
  localparam int SW = FW + PAD_W;
  localparam int CW = $clog2(SW + 1);
  localparam int PW = $clog2(GROUP);

  fs_t           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, nbits, slen;
  logic [PW-1:0] ph_q, ph_d, ph_nx;
  logic          mk, idle, evt;

  assign mk    = marker_at(win_nx[FW-2], win_nx[FW-1]);
  assign idle  = ~|win_nx;
  assign nbits = cnt_q + 1'b1;
  assign slen  = CW'(slot_bits(pad_mode, ph_q == '0, FW, PAD_W));
  assign ph_nx = (ph_q == PW'(GROUP - 1)) ? '0 : ph_q + 1'b1;
  assign word  = win_nx[DATA_W-1:0];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    evt   = 1'b0;
    case (st_q)
      FS_HUNT: begin
        if (mk) begin
          st_d  = FS_CONFIRM;
          cnt_d = '0;
        end
      end
      FS_CONFIRM: begin
        cnt_d = nbits;
        if (nbits == CW'(FW)) begin
          if (mk && !pad_mode) begin
            st_d  = FS_TRACK;
            cnt_d = '0;
            ph_d  = PW'(1);
            evt   = 1'b1;
          end else if (mk) begin
            cnt_d = '0;              // a 14-bit gap re-arms the search for the padded gap
          end else if (!pad_mode) begin
            st_d = FS_HUNT;
          end
        end else if (nbits == CW'(SW)) begin
          if (mk) begin
            st_d  = FS_TRACK;
            cnt_d = '0;
            ph_d  = PW'(1);
            evt   = 1'b1;
          end else begin
            st_d = FS_HUNT;
          end
        end
      end
      FS_TRACK: begin
        cnt_d = nbits;
        if (nbits == slen) begin
          cnt_d = '0;
          ph_d  = ph_nx;
          if (mk)         evt  = 1'b1;
          else if (!idle) st_d = FS_HUNT;
        end
      end
      default: st_d = FS_HUNT;
    endcase
  end

  assign word_evt = evt && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_HUNT;
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (!run) begin
      st_q  <= FS_HUNT;
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // Checker-only gap counter between output words.
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= CW'(FW);
    else if (!run)              gap_q <= CW'(FW);
    else if (word_evt)          gap_q <= '0;
    else if (gap_q != CW'(FW))  gap_q <= gap_q + 1'b1;
  end

  AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_evt |-> (gap_q >= CW'(FW - 1))); // R1

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_TRACK && $past(st_q) != FS_TRACK) |-> ($past(st_q) == FS_CONFIRM)); // R2

endmodule

// File: rtl/dsr_wclk.sv
module dsr_wclk #(
  parameter int FALL_DLY = 8,
  parameter int LOW_LEN  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic word_evt,
  output logic wclk
);

  localparam int LW = $clog2(LOW_LEN + 1);

  logic [FALL_DLY-1:0] dly_q;
  logic [LW-1:0]       low_q;
  logic                fall_req;

  assign fall_req = dly_q[FALL_DLY-1];
  assign wclk     = (low_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      low_q <= '0;
    end else if (!run) begin
      dly_q <= '0;
      low_q <= '0;
    end else begin
      dly_q <= {dly_q[FALL_DLY-2:0], word_evt};
      if (fall_req)          low_q <= LW'(LOW_LEN);
      else if (low_q != '0)  low_q <= low_q - 1'b1;
    end
  end

  AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fall_req |-> (low_q == '0)); // R7

endmodule

// File: rtl/framed_deser.sv
module framed_deser #(
  parameter int DATA_W   = 12,
  parameter int PAD_W    = 2,
  parameter int GROUP    = 3,
  parameter int FALL_DLY = 8,
  parameter int LOW_LEN  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir_tx,
  input  logic              pad_mode,
  input  logic              sdata,
  output logic [DATA_W-1:0] dp_o,
  output logic              dp_oe,
  output logic              wclk
);

  localparam int FW = DATA_W + 2;

  logic              run;
  logic [FW-1:0]     win_nx;
  logic              word_evt;
  logic [DATA_W-1:0] word;

  assign run   = en & ~dir_tx;
  assign dp_oe = run;

  dsr_shift #(.W(FW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~run),
    .sin    (sdata),
    .win_nx (win_nx)
  );

  dsr_framer #(.DATA_W(DATA_W), .PAD_W(PAD_W), .GROUP(GROUP)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pad_mode (pad_mode),
    .win_nx   (win_nx),
    .word_evt (word_evt),
    .word     (word)
  );

  dsr_wclk #(.FALL_DLY(FALL_DLY), .LOW_LEN(LOW_LEN)) u_wclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .word_evt (word_evt),
    .wclk     (wclk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dp_o <= '0;
    else if (!en)      dp_o <= '0;
    else if (word_evt) dp_o <= word;
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_tx) |=> (dp_o == $past(dp_o))); // R8

  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dp_o == '0 && wclk)); // R9

endmodule

// File: tb/sim_framed_deser.sv
module sim_framed_deser;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic dir_tx = 1'b0;
  logic pad_mode = 1'b0;
  logic sdata = 1'b0;
  wire [11:0] dp_o;
  wire dp_oe;
  wire wclk;

  framed_deser u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx), .pad_mode(pad_mode),
    .sdata(sdata), .dp_o(dp_o), .dp_oe(dp_oe), .wclk(wclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int ec = 0;
  int evq[$];
  logic [11:0] dp_exp = '0;
  bit pend_ev = 1'b0;
  logic [11:0] pend_w = '0;
  string req = "R10";

  // Pulse of word emitted at edge E: low after edges E+8 .. E+20 (R7).
  function automatic bit wclk_exp();
    foreach (evq[i]) if (ec >= evq[i] + 8 && ec <= evq[i] + 20) return 1'b0;
    return 1'b1;
  endfunction

  task automatic apply_edge();
    ec++;
    if (!rst_n || !en) begin
      dp_exp = '0;
      evq.delete();
    end else if (dir_tx) begin
      evq.delete();
    end else if (pend_ev) begin
      dp_exp = pend_w;
      evq.push_back(ec);
    end
    while (evq.size() > 0 && evq[0] + 20 < ec) void'(evq.pop_front());
  endtask

  task automatic check_now();
    logic oe_x;
    bit   wk_x;
    oe_x = en & ~dir_tx;
    wk_x = wclk_exp();
    n_run++;
    if (dp_o !== dp_exp || dp_oe !== oe_x || wclk !== wk_x) begin
      n_fail++;
      $display("FAIL %s edge=%0d dp_o=%h exp %h dp_oe=%b exp %b wclk=%b exp %b",
               req, ec, dp_o, dp_exp, dp_oe, oe_x, wclk, wk_x);
    end
  endtask

  task automatic step(input bit b, input bit ev, input logic [11:0] w);
    @(negedge clk);
    apply_edge();
    check_now();
    sdata   = b;
    pend_ev = ev;
    pend_w  = w;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
  endtask

  task automatic idle_frame();
    zeros(14);
  endtask

  task automatic pad2(input bit a, input bit b);
    step(a, 1'b0, '0);
    step(b, 1'b0, '0);
  endtask

  // R1: data bit 0 first, then marker 1, marker 0
  task automatic frame(input logic [11:0] w, input bit emit);
    for (int i = 0; i < 12; i++) step(w[i], 1'b0, '0);
    step(1'b1, 1'b0, '0);
    step(1'b0, emit, w);
  endtask

  task automatic junk_frame();
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, '0);
  endtask

  initial begin
    req = "R10";
    zeros(3);
    rst_n = 1'b1;
    idle_frame();
    idle_frame();

    // Acquisition, word order, output timing, back-to-back pulses
    req = "R1 R2 R6 R7";
    frame(12'hF00, 1'b0);
    frame(12'h5A3, 1'b1);
    frame(12'h0C7, 1'b1);
    frame(12'hFFF, 1'b1);
    frame(12'h000, 1'b1);
    frame(12'h801, 1'b1);

    req = "R4";
    idle_frame();
    frame(12'h123, 1'b1);
    idle_frame();
    idle_frame();
    frame(12'hABC, 1'b1);
    idle_frame();
    idle_frame();

    req = "R5";
    junk_frame();
    idle_frame();
    idle_frame();
    frame(12'hF00, 1'b0);
    frame(12'h9E1, 1'b1);
    frame(12'h3C3, 1'b1);

    req = "R8";
    zeros(4);
    dir_tx = 1'b1;
    zeros(10);
    frame(12'h321, 1'b0);
    frame(12'hF00, 1'b0);
    frame(12'h654, 1'b0);
    idle_frame();
    dir_tx = 1'b0;
    idle_frame();
    frame(12'hF00, 1'b0);
    frame(12'h777, 1'b1);
    idle_frame();
    idle_frame();

    req = "R9";
    en = 1'b0;
    zeros(20);
    pad_mode = 1'b1;
    en = 1'b1;

    req = "R3";
    pad2(1'b0, 1'b0); idle_frame();
    idle_frame();
    idle_frame();
    pad2(1'b0, 1'b0); idle_frame();
    idle_frame();
    frame(12'hF00, 1'b0);
    pad2(1'b0, 1'b0); frame(12'hF00, 1'b1);
    frame(12'h2B4, 1'b1);
    frame(12'h4C1, 1'b1);
    pad2(1'b1, 1'b1); frame(12'hAAA, 1'b1);
    idle_frame();
    frame(12'h135, 1'b1);
    pad2(1'b0, 1'b1); frame(12'hE0E, 1'b1);
    frame(12'h0F0, 1'b1);

    req = "R9";
    zeros(3);
    en = 1'b0;
    zeros(16);
    en = 1'b1;
    zeros(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in %s", req);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule